// File: doc/BRIEF.md
# Push-Pull Digital PWM Core

This block drives a two-switch push-pull stage from a counter ramp. Each oscillator cycle has two parts. First a ramp phase counts from zero up to a per-cycle period value. Then a deadtime phase follows, during which the oscillator pulse output is high and both drives are held off. A pulse starts at the beginning of the ramp and ends when the ramp count reaches the effective threshold. The effective threshold is the smaller of the duty command and the soft-start limit. Once a pulse has ended, a set-dominant latch keeps it off until the next cycle starts, so raising the command part way through a cycle cannot start a second pulse.

A phase bit flips at the start of every cycle and sends the pulse to drive A on one cycle and to drive B on the next. Each drive therefore runs at half the oscillator rate. Because the deadtime phase is never shorter than one clock, each drive stays below 50% duty. A rising edge on the sync input ends the ramp early, which lets several cores be slaved to a common clock. The shutdown input sets the latch, which cuts the current pulse at the next clock edge. The polarity select picks between two output forms: active-high drives that are low when off, or the complementary form that is high when off.

Top module: `pp_pwm_core`

## Requirements
- R1: Drive A and drive B are never on in the same clock, and the side that conducts changes at every cycle start.
- R2: With polarity select 0, a drive is high only in a ramp clock whose count is below the effective threshold, only on its own cycle, and only while the latch is clear. It is low at all other times. A ramp of period value P lasts P+1 clocks, with counts 0 to P.
- R3: With polarity select 1, each drive is the inverse of its polarity-0 value, so it is high whenever it is off. This includes reset and shutdown.
- R4: Once the ramp count reaches the threshold within a cycle, that drive stays off until the next cycle starts, even if the threshold is raised afterwards.
- R5: If shutdown is high at a clock edge, no drive is on after that edge. A shutdown that lasts only one clock affects only the cycle it occurs in. Shutdown held high keeps both drives off in every cycle.
- R6: After each ramp, a deadtime of D+1 clocks follows, where D is the deadtime length captured for that cycle. During the deadtime the oscillator pulse output is high and both drives are off. The oscillator pulse output is low throughout the ramp.
- R7: An effective threshold of 0 gives zero duty. With period 9, deadtime 0 and a full-scale threshold, each drive is on for exactly 100 of any 220 consecutive clocks, which is below half.
- R8: A rising edge on sync (sync high at an edge after being low at the previous edge) during the ramp ends the ramp. The deadtime starts at the next clock.
- R9: A sync edge that falls inside the deadtime has no effect. The deadtime still lasts D+1 clocks.
- R10: The effective threshold is the minimum of the duty command and the soft-start limit.
- R11: The period and deadtime length are captured only at the start of a cycle. Changes in the middle of a cycle take effect in the following cycle.
- R12: During reset, both drives are off and the oscillator pulse output is high. The first cycle after reset is released drives A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| duty_cmd | input | CNT_W | Duty command, in ramp counts |
| ss_limit | input | CNT_W | Soft-start ceiling on the threshold |
| sync_in | input | 1 | External sync; a rising edge ends the ramp |
| shutdown | input | 1 | Sets the pulse latch |
| dead_len | input | DT_W | Deadtime length D (deadtime lasts D+1 clocks) |
| period | input | CNT_W | Ramp top count P |
| pol_or | input | 1 | 0: drives high when on; 1: drives high when off |
| drive_a | output | 1 | Drive for side A |
| drive_b | output | 1 | Drive for side B |
| osc_pulse | output | 1 | High during the deadtime |

## Verification
The hardest case to reach from the ports is a change that lands in the middle of a cycle. Examples are a threshold raised after the latch has set, a period or deadtime rewritten half-way through a ramp, and a sync edge arriving inside the deadtime. The stimulus changes these inputs every few clocks, on short periods and with varying deadtimes, so the changes land at many different ramp positions. A behavioural model in the bench tracks the cycle and is compared against the three outputs on every clock. Counting windows that span a whole number of two-cycle periods measure the duty limits without depending on where the window is aligned.

// File: rtl/pp_pwm_pkg.sv
package pp_pwm_pkg;
  typedef enum logic {OSC_RAMP = 1'b0, OSC_DEAD = 1'b1} osc_st_e;
  typedef enum logic {POL_NOR = 1'b0, POL_OR = 1'b1} pol_e;
endpackage

// File: rtl/pp_ramp_osc.sv
module pp_ramp_osc
  import pp_pwm_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DT_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period,
  input  logic [DT_W-1:0]  dead_len,
  input  logic             sync_in,
  output logic [CNT_W-1:0] ramp,
  output logic             in_dead,
  output logic             cyc_start
);
  osc_st_e          st;
  logic [DT_W-1:0]  dcnt;
  logic [DT_W-1:0]  dt_q;
  logic [CNT_W-1:0] per_q;
  logic             sync_q;
  logic             sync_rise;
  logic             ramp_end;

  function automatic logic at_top(input logic [CNT_W-1:0] r, input logic [CNT_W-1:0] p);
    return r == p;
  endfunction

  assign sync_rise = sync_in & ~sync_q;
  assign in_dead   = (st == OSC_DEAD);
  assign cyc_start = in_dead && (dcnt == dt_q);
  assign ramp_end  = !in_dead && (sync_rise || at_top(ramp, per_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= OSC_DEAD;
      dcnt   <= '0;
      dt_q   <= '0;
      per_q  <= '0;
      ramp   <= '0;
      sync_q <= 1'b0;
    end else begin
      sync_q <= sync_in;
      if (cyc_start) begin
        st    <= OSC_RAMP;
        ramp  <= '0;
        per_q <= period;
        dt_q  <= dead_len;
      end else if (in_dead) begin
        dcnt <= dcnt + 1'b1;
      end else if (ramp_end) begin
        st   <= OSC_DEAD;
        dcnt <= '0;
      end else begin
        ramp <= ramp + 1'b1;
      end
    end
  end

  // R2
  ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_dead && !ramp_end) |=> (ramp == $past(ramp) + 1'b1));

  // R9
  dead_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_dead && !cyc_start) |=> in_dead);

  // R6
  dead_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_end |=> (in_dead && dcnt == '0));
endmodule

// File: rtl/pp_pwm_latch.sv
module pp_pwm_latch #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_start,
  input  logic             in_dead,
  input  logic [CNT_W-1:0] ramp,
  input  logic [CNT_W-1:0] duty_cmd,
  input  logic [CNT_W-1:0] ss_limit,
  input  logic             shutdown,
  output logic             pwm_on
);
  logic             latch_q;
  logic [CNT_W-1:0] thr;
  logic             below;

  function automatic logic [CNT_W-1:0] eff_thr(input logic [CNT_W-1:0] cmd,
                                               input logic [CNT_W-1:0] lim);
    return (cmd < lim) ? cmd : lim;
  endfunction

  assign thr    = eff_thr(duty_cmd, ss_limit);
  assign below  = ramp < thr;
  assign pwm_on = ~in_dead & ~latch_q & below;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          latch_q <= 1'b0;
    else if (cyc_start)  latch_q <= shutdown;
    else if (in_dead)    latch_q <= latch_q | shutdown;
    else                 latch_q <= latch_q | shutdown | ~below;
  end

  // R4
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && !cyc_start) |=> latch_q);

  // R5
  shutdown_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> !pwm_on);
endmodule

// File: rtl/pp_out_steer.sv
module pp_out_steer
  import pp_pwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_start,
  input  logic       pwm_on,
  input  logic       pol_or,
  output logic [1:0] drive
);
  logic       phase_q;
  logic [1:0] side_on;
  pol_e       pol;

  assign pol = pol_e'(pol_or);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         phase_q <= 1'b1;
    else if (cyc_start) phase_q <= ~phase_q;
  end

  for (genvar g = 0; g < 2; g++) begin : g_side
    assign side_on[g] = pwm_on & (phase_q == 1'(g));
    assign drive[g]   = (pol == POL_OR) ? ~side_on[g] : side_on[g];
  end

  // R1
  phase_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> (phase_q != $past(phase_q)));

  // R1
  no_handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    side_on[0] |=> !side_on[1]);
endmodule

// File: rtl/pp_pwm_core.sv
module pp_pwm_core #(
  parameter int CNT_W = 8,
  parameter int DT_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] duty_cmd,
  input  logic [CNT_W-1:0] ss_limit,
  input  logic             sync_in,
  input  logic             shutdown,
  input  logic [DT_W-1:0]  dead_len,
  input  logic [CNT_W-1:0] period,
  input  logic             pol_or,
  output logic             drive_a,
  output logic             drive_b,
  output logic             osc_pulse
);
  logic [CNT_W-1:0] ramp;
  logic             in_dead;
  logic             cyc_start;
  logic             pwm_on;
  logic [1:0]       drive;

  pp_ramp_osc #(.CNT_W(CNT_W), .DT_W(DT_W)) u_osc (
    .clk(clk), .rst_n(rst_n), .period(period), .dead_len(dead_len),
    .sync_in(sync_in), .ramp(ramp), .in_dead(in_dead), .cyc_start(cyc_start)
  );

  pp_pwm_latch #(.CNT_W(CNT_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .in_dead(in_dead),
    .ramp(ramp), .duty_cmd(duty_cmd), .ss_limit(ss_limit),
    .shutdown(shutdown), .pwm_on(pwm_on)
  );

  pp_out_steer u_steer (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .pwm_on(pwm_on),
    .pol_or(pol_or), .drive(drive)
  );

  assign drive_a   = drive[0];
  assign drive_b   = drive[1];
  assign osc_pulse = in_dead;

  // R6
  pulse_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    osc_pulse |-> (drive_a == pol_or && drive_b == pol_or));
endmodule

// File: tb/pp_pwm_core_test.sv
module pp_pwm_core_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] duty_cmd = 8'd0;
  logic [7:0] ss_limit = 8'd255;
  logic       sync_in = 1'b0;
  logic       shutdown = 1'b0;
  logic [3:0] dead_len = 4'd1;
  logic [7:0] period = 8'd9;
  logic       pol_or = 1'b0;
  logic       drive_a, drive_b, osc_pulse;

  pp_pwm_core uut (
    .clk(clk), .rst_n(rst_n), .duty_cmd(duty_cmd), .ss_limit(ss_limit),
    .sync_in(sync_in), .shutdown(shutdown), .dead_len(dead_len),
    .period(period), .pol_or(pol_or), .drive_a(drive_a), .drive_b(drive_b),
    .osc_pulse(osc_pulse)
  );

  always #5 clk = ~clk;

  int    checks = 0, fails = 0;
  bit    running = 0, done = 0, window = 0;
  string cur = "R12";
  int    cnt_a = 0, cnt_b = 0, overlap = 0;

  // behavioural reference state
  int m_dead = 1, m_dcnt = 0, m_dt = 0, m_per = 0, m_ramp = 0;
  int m_latch = 0, m_phase = 1, m_sp = 0;

  function automatic int min2(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dead = 1; m_dcnt = 0; m_dt = 0; m_per = 0; m_ramp = 0;
      m_latch = 0; m_phase = 1; m_sp = 0;
    end else begin
      int rise, thr;
      rise = (sync_in && !m_sp) ? 1 : 0;
      m_sp = sync_in;
      thr  = min2(duty_cmd, ss_limit);
      if (m_dead != 0) begin
        if (m_dcnt == m_dt) begin
          m_dead = 0; m_ramp = 0; m_per = period; m_dt = dead_len;
          m_latch = shutdown; m_phase = 1 - m_phase;
        end else begin
          m_dcnt++;
          if (shutdown) m_latch = 1;
        end
      end else begin
        if (shutdown || m_ramp >= thr) m_latch = 1;
        if (rise != 0 || m_ramp == m_per) begin
          m_dead = 1; m_dcnt = 0;
        end else m_ramp++;
      end
    end
  end

  always @(negedge clk) begin
    if (running) begin
      int on, ea, eb, oa, ob;
      on = (m_dead == 0 && m_latch == 0 && m_ramp < min2(duty_cmd, ss_limit)) ? 1 : 0;
      oa = (on != 0 && m_phase == 0) ? 1 : 0;
      ob = (on != 0 && m_phase == 1) ? 1 : 0;
      ea = pol_or ? 1 - oa : oa;
      eb = pol_or ? 1 - ob : ob;
      chk(cur, "drive_a", int'(drive_a), ea);
      chk(cur, "drive_b", int'(drive_b), eb);
      chk(cur, "osc_pulse", int'(osc_pulse), m_dead);
      if ((drive_a ^ pol_or) && (drive_b ^ pol_or)) overlap++;
      if (window) begin
        if (drive_a ^ pol_or) cnt_a++;
        if (drive_b ^ pol_or) cnt_b++;
      end
    end
  end

  task automatic tick(int n);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  initial begin
    int lcg;
    lcg = 7;
    tick(3);
    // R12 reset state
    chk("R12", "reset drive_a", int'(drive_a), 0);
    chk("R12", "reset drive_b", int'(drive_b), 0);
    chk("R12", "reset osc_pulse", int'(osc_pulse), 1);
    pol_or = 1'b1;
    #1;
    chk("R3", "reset drive_a inverted", int'(drive_a), 1);
    chk("R3", "reset drive_b inverted", int'(drive_b), 1);
    pol_or = 1'b0;
    rst_n = 1'b1;
    running = 1;
    duty_cmd = 8'd4;
    tick(4);
    chk("R12", "first cycle drives A", int'(drive_a), 1);
    cur = "R2";  tick(60);
    cur = "R10"; ss_limit = 8'd2; tick(40);
    ss_limit = 8'd3; duty_cmd = 8'd6; tick(40);
    duty_cmd = 8'd1; tick(30);
    ss_limit = 8'd255;
    cur = "R6";  duty_cmd = 8'd5; dead_len = 4'd5; tick(60);
    dead_len = 4'd0; tick(40);
    cur = "R11";
    for (int i = 0; i < 50; i++) begin
      lcg = (lcg * 37 + 11) % 1024;
      period = 8'(2 + lcg % 14);
      dead_len = 4'(lcg % 7);
      duty_cmd = 8'(lcg % 12);
      tick(3);
    end
    cur = "R4"; period = 8'd20; dead_len = 4'd2;
    for (int i = 0; i < 20; i++) begin
      duty_cmd = 8'd3;  tick(4);
      duty_cmd = 8'd30; tick(3);
    end
    cur = "R5"; duty_cmd = 8'd15;
    for (int i = 0; i < 6; i++) begin
      shutdown = 1'b1; tick(1);
      shutdown = 1'b0; tick(9);
    end
    shutdown = 1'b1; tick(60);
    shutdown = 1'b0; tick(30);
    cur = "R3"; pol_or = 1'b1; tick(50);
    shutdown = 1'b1; tick(10);
    chk("R3", "shutdown drive_a high", int'(drive_a), 1);
    chk("R3", "shutdown drive_b high", int'(drive_b), 1);
    shutdown = 1'b0; pol_or = 1'b0;
    cur = "R8"; period = 8'd40; duty_cmd = 8'd255; dead_len = 4'd1;
    for (int i = 0; i < 10; i++) begin
      sync_in = 1'b1; tick(1);
      sync_in = 1'b0; tick(12);
    end
    cur = "R9"; dead_len = 4'd7; period = 8'd6;
    for (int i = 0; i < 60; i++) begin
      sync_in = ~sync_in; tick(1);
    end
    sync_in = 1'b0;
    cur = "R7"; period = 8'd9; dead_len = 4'd0; duty_cmd = 8'd255; ss_limit = 8'd255;
    tick(40);
    cnt_a = 0; cnt_b = 0; window = 1; tick(220); window = 0;
    chk("R7", "max duty A count", cnt_a, 100);
    chk("R7", "max duty B count", cnt_b, 100);
    duty_cmd = 8'd0; tick(10);
    cnt_a = 0; cnt_b = 0; window = 1; tick(100); window = 0;
    chk("R7", "zero duty A count", cnt_a, 0);
    chk("R7", "zero duty B count", cnt_b, 0);
    running = 0;
    chk("R1", "overlap clocks", overlap, 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule